// File: doc/BRIEF.md
# Dual Potentiometer I2C Command Front End

This block is the serial front end of a two-channel digital potentiometer. It watches an I2C-compatible bus (SCL and SDA) with a faster system clock. It finds START and STOP conditions and answers a 7-bit address. The address is a fixed five-bit prefix plus two bits taken from strap pins, or the constant `11` when the part is built with a fixed address. SDA is driven only through an open-drain enable: `sda_oe` high pulls the line low.

A write transaction has three parts: the address byte, an instruction byte, then one or more data bytes. The instruction byte picks the channel and carries the shutdown, fuse-program and override control bits. Every data byte after it produces one write item for the wiper controller, which sits outside this block. The write items leave on a valid/ready interface. An item is held until `wr_ready` is seen. The bus cannot be stalled, so when a new data byte completes while an item is still waiting, the newer item replaces it: the latest value wins.

A read transaction returns the wiper of the channel that the most recent accepted instruction selected. It is followed by a status byte, and the two bytes alternate for as long as the master acknowledges.

Top module: `pot_i2c_frontend`

## Requirements
- R1: After reset `sda_oe` is low and `wr_valid` is low.
- R2: The slave acknowledges an address byte whose upper seven bits equal `01011` followed by `addr_pins_i[1]` and `addr_pins_i[0]` (or `11` when FIXED_ADDR is set). The LSB selects the direction: 0 is write, 1 is read. The acknowledge is SDA held low during the ninth SCL clock.
- R3: On an address mismatch the slave gives no acknowledge. It drives nothing and issues no write item for the rest of the transaction, until the next START.
- R4: The instruction byte is acknowledged. Its fields are: bit 7 channel (0 = channel A, 1 = channel B), bit 6 shutdown, bit 5 fuse program, bit 4 reserved (must be 0), bit 3 override. Bits 2..0 are ignored.
- R5: Each data byte of a write is acknowledged and yields exactly one write item carrying the instruction's channel, shutdown, fuse and override bits and the data byte. Further data bytes in the same transaction each yield a new item.
- R6: An instruction with the reserved bit set is acknowledged, but its data bytes yield no items and the selected channel stays unchanged.
- R7: The first byte of a read is the wiper of the selected channel, sent MSB first.
- R8: After each byte the master acknowledges, the next byte alternates between the status byte `{E1,E0,000000}` (taken from `fuse_status_i[1:0]`) and the wiper byte. A missing master acknowledge ends the read, and SDA is released.
- R9: `sda_oe` changes only while SCL is low, except that a START or STOP releases it.
- R10: `wr_valid` stays high until a cycle with `wr_ready` high. If a further data byte completes while an item is pending, the pending item is replaced by the newer one.
- R11: A START inside a transaction (a repeated START) restarts address reception. A STOP returns the slave to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe | output | 1 | Open-drain enable: 1 pulls SDA low |
| addr_pins_i | input | 2 | Strapped low address bits |
| wiper_a_i | input | 8 | Current wiper of channel A for readback |
| wiper_b_i | input | 8 | Current wiper of channel B for readback |
| fuse_status_i | input | 2 | Validation bits {E1,E0} |
| wr_valid | output | 1 | Write item pending |
| wr_ready | input | 1 | Controller accepts the pending item |
| wr_chan | output | 1 | Target channel (0 = A, 1 = B) |
| wr_shutdown | output | 1 | Shutdown control bit |
| wr_fuse | output | 1 | Fuse program control bit |
| wr_override | output | 1 | Override control bit |
| wr_data | output | 8 | New wiper code |

## Verification
The hardest case to reach from the ports is the replace-while-pending path of the write interface. It needs a stalled consumer while the bus keeps delivering data bytes. The bench holds `wr_ready` low across a two-byte write, checks at the ports that the held item is the second byte, and only then releases `wr_ready`. The scoreboard expects exactly one item. The read alternation is reached with a three-byte read that acknowledges twice. Selection retention is reached with a reserved-bit instruction followed by a read.

// File: rtl/pot_i2c_pkg.sv
`timescale 1ns/1ps
package pot_i2c_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_INSTR,
    ST_WDATA,
    ST_RDATA,
    ST_IGNORE
  } link_state_t;

  typedef struct packed {
    logic chan;
    logic shutdown;
    logic fuse;
    logic reserved;
    logic override;
  } instr_t;

  typedef struct packed {
    logic              chan;
    logic              shutdown;
    logic              fuse;
    logic              override;
    logic [BYTE_W-1:0] data;
  } wr_item_t;
endpackage

// File: rtl/pot_i2c_sync.sv
`timescale 1ns/1ps
module pot_i2c_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic bus_start,
  output logic bus_stop
);
  // bit 1 = SCL, bit 0 = SDA
  logic [STAGES-1:0][1:0] pipe;
  logic [1:0]             last;
  logic [1:0]             cur;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe <= '1;
      last <= 2'b11;
    end else begin
      pipe <= {pipe[STAGES-2:0], {scl_i, sda_i}};
      last <= pipe[STAGES-1];
    end
  end

  assign cur       = pipe[STAGES-1];
  assign sda_s     = cur[0];
  assign scl_rise  = cur[1] & ~last[1];
  assign scl_fall  = ~cur[1] & last[1];
  assign bus_start = cur[1] & last[1] & last[0] & ~cur[0];
  assign bus_stop  = cur[1] & last[1] & ~last[0] & cur[0];
endmodule

// File: rtl/pot_i2c_link.sv
`timescale 1ns/1ps
module pot_i2c_link
  import pot_i2c_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              bus_start,
  input  logic              bus_stop,
  input  logic [6:0]        my_addr,
  input  logic [BYTE_W-1:0] tx_byte,
  output logic              sda_oe,
  output logic              instr_stb,
  output logic              data_stb,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              tx_sel
);
  localparam logic [3:0] LAST_BIT = 4'd8;

  link_state_t       state;
  logic [3:0]        bitcnt;
  logic [BYTE_W-1:0] shreg;
  logic              go_read;
  logic              counting;

  assign rx_byte  = shreg;
  assign counting = (state != ST_IDLE) && (state != ST_IGNORE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      bitcnt    <= '0;
      shreg     <= '0;
      go_read   <= 1'b0;
      sda_oe    <= 1'b0;
      tx_sel    <= 1'b0;
      instr_stb <= 1'b0;
      data_stb  <= 1'b0;
    end else begin
      instr_stb <= 1'b0;
      data_stb  <= 1'b0;
      if (bus_start) begin
        state  <= ST_ADDR;
        bitcnt <= '0;
        sda_oe <= 1'b0;
        tx_sel <= 1'b0;
      end else if (bus_stop) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
      end else if (scl_rise) begin
        case (state)
          ST_IDLE, ST_IGNORE: ;
          ST_RDATA: begin
            if (bitcnt == LAST_BIT) begin
              if (sda_s) state <= ST_IGNORE;   // master did not acknowledge
              else       tx_sel <= ~tx_sel;
            end
          end
          default: begin
            if (bitcnt < LAST_BIT) shreg <= {shreg[BYTE_W-2:0], sda_s};
          end
        endcase
        if (counting) bitcnt <= (bitcnt == LAST_BIT) ? 4'd0 : 4'(bitcnt + 4'd1);
      end else if (scl_fall) begin
        case (state)
          ST_ADDR: begin
            if (bitcnt == LAST_BIT) begin
              if (shreg[7:1] == my_addr) begin
                state   <= ST_ADDR_ACK;
                sda_oe  <= 1'b1;
                go_read <= shreg[0];
              end else begin
                state <= ST_IGNORE;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (bitcnt == 4'd0) begin
              if (go_read) begin
                state  <= ST_RDATA;
                sda_oe <= ~tx_byte[BYTE_W-1];
              end else begin
                state  <= ST_INSTR;
                sda_oe <= 1'b0;
              end
            end
          end
          ST_INSTR: begin
            if (bitcnt == LAST_BIT) begin
              sda_oe    <= 1'b1;
              instr_stb <= 1'b1;
              state     <= ST_WDATA;
            end else if (bitcnt == 4'd0) begin
              sda_oe <= 1'b0;
            end
          end
          ST_WDATA: begin
            if (bitcnt == LAST_BIT) begin
              sda_oe   <= 1'b1;
              data_stb <= 1'b1;
            end else if (bitcnt == 4'd0) begin
              sda_oe <= 1'b0;
            end
          end
          ST_RDATA: begin
            sda_oe <= (bitcnt < LAST_BIT) ? ~tx_byte[~bitcnt[2:0]] : 1'b0;
          end
          default: sda_oe <= 1'b0;
        endcase
      end
    end
  end
endmodule

// File: rtl/pot_i2c_cmd.sv
`timescale 1ns/1ps
module pot_i2c_cmd
  import pot_i2c_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              instr_stb,
  input  logic              data_stb,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              tx_sel,
  input  logic [BYTE_W-1:0] wiper_a_i,
  input  logic [BYTE_W-1:0] wiper_b_i,
  input  logic [1:0]        fuse_status_i,
  output logic [BYTE_W-1:0] tx_byte,
  input  logic              wr_ready,
  output logic              wr_valid,
  output wr_item_t          wr_item
);
  instr_t ins;
  logic   sel_chan;
  logic   unused_low;

  assign unused_low = ^rx_byte[2:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ins      <= '0;
      sel_chan <= 1'b0;
    end else if (instr_stb) begin
      ins <= '{chan: rx_byte[7], shutdown: rx_byte[6], fuse: rx_byte[5],
               reserved: rx_byte[4], override: rx_byte[3]};
      if (!rx_byte[4]) sel_chan <= rx_byte[7];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_valid <= 1'b0;
      wr_item  <= '0;
    end else if (data_stb && !ins.reserved) begin
      wr_valid <= 1'b1;
      wr_item  <= '{chan: ins.chan, shutdown: ins.shutdown, fuse: ins.fuse,
                    override: ins.override, data: rx_byte};
    end else if (wr_valid && wr_ready) begin
      wr_valid <= 1'b0;
    end
  end

  always_comb begin
    if (tx_sel)        tx_byte = {fuse_status_i, {(BYTE_W-2){1'b0}}};
    else if (sel_chan) tx_byte = wiper_b_i;
    else               tx_byte = wiper_a_i;
  end
endmodule

// File: rtl/pot_i2c_frontend.sv
`timescale 1ns/1ps
module pot_i2c_frontend
  import pot_i2c_pkg::*;
#(
  parameter logic [4:0] ADDR_PREFIX = 5'b01011,
  parameter bit         FIXED_ADDR  = 1'b0,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic [1:0]        addr_pins_i,
  input  logic [BYTE_W-1:0] wiper_a_i,
  input  logic [BYTE_W-1:0] wiper_b_i,
  input  logic [1:0]        fuse_status_i,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic              wr_chan,
  output logic              wr_shutdown,
  output logic              wr_fuse,
  output logic              wr_override,
  output logic [BYTE_W-1:0] wr_data
);
  logic              sda_s, scl_rise, scl_fall, bus_start, bus_stop;
  logic              instr_stb, data_stb, tx_sel;
  logic [BYTE_W-1:0] rx_byte, tx_byte;
  logic [1:0]        low_bits;
  wr_item_t          item;

  generate
    if (FIXED_ADDR) begin : g_fixed
      logic unused_pins;
      assign unused_pins = ^addr_pins_i;
      assign low_bits    = 2'b11;
    end else begin : g_strap
      assign low_bits = addr_pins_i;
    end
  endgenerate

  pot_i2c_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .bus_start(bus_start), .bus_stop(bus_stop)
  );

  pot_i2c_link u_link (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .bus_start(bus_start), .bus_stop(bus_stop),
    .my_addr({ADDR_PREFIX, low_bits}), .tx_byte(tx_byte), .sda_oe(sda_oe),
    .instr_stb(instr_stb), .data_stb(data_stb), .rx_byte(rx_byte),
    .tx_sel(tx_sel)
  );

  pot_i2c_cmd u_cmd (
    .clk(clk), .rst_n(rst_n), .instr_stb(instr_stb), .data_stb(data_stb),
    .rx_byte(rx_byte), .tx_sel(tx_sel), .wiper_a_i(wiper_a_i),
    .wiper_b_i(wiper_b_i), .fuse_status_i(fuse_status_i),
    .tx_byte(tx_byte), .wr_ready(wr_ready), .wr_valid(wr_valid),
    .wr_item(item)
  );

  assign wr_chan     = item.chan;
  assign wr_shutdown = item.shutdown;
  assign wr_fuse     = item.fuse;
  assign wr_override = item.override;
  assign wr_data     = item.data;
endmodule

// File: rtl/pot_i2c_checker.sv
`timescale 1ns/1ps
module pot_i2c_checker (
  input logic clk,
  input logic rst_n,
  input logic scl_i,
  input logic sda_oe,
  input logic wr_valid,
  input logic wr_ready
);
  // R9: the open-drain enable moves only while the bus clock is low
  p_oe_scl_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_i);

  // R5: a new write item appears during the acknowledge of its data byte
  p_item_with_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_valid) |-> sda_oe);

  // R5: a new write item never appears while SCL is high
  p_item_scl_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_valid) |-> !scl_i);

  // R10: a pending item stays pending until accepted
  p_hold_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid);
endmodule

bind pot_i2c_frontend pot_i2c_checker u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe),
  .wr_valid(wr_valid), .wr_ready(wr_ready)
);

// File: tb/tb_pot_i2c_frontend.sv
`timescale 1ns/1ps
module tb_pot_i2c_frontend;
  localparam int CLK_PERIOD = 10;
  localparam int Q          = 10;   // quarter of an SCL bit, in clocks

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl = 1'b1;
  logic       m_sda = 1'b1;
  logic       sda_oe;
  logic       sda_line;
  logic [7:0] wiper_a = 8'h21;
  logic [7:0] wiper_b = 8'h9A;
  logic [1:0] fstat = 2'b10;
  logic       wr_valid, wr_ready = 1'b1;
  logic       wr_chan, wr_shutdown, wr_fuse, wr_override;
  logic [7:0] wr_data;

  int n_cmp = 0;
  int n_bad = 0;
  int bad_oe = 0;
  logic oe_last = 1'b0;
  bit done = 1'b0;
  logic [11:0] exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sda_line = m_sda & ~sda_oe;

  pot_i2c_frontend dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .addr_pins_i(2'b10), .wiper_a_i(wiper_a), .wiper_b_i(wiper_b),
    .fuse_status_i(fstat), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_chan(wr_chan), .wr_shutdown(wr_shutdown), .wr_fuse(wr_fuse),
    .wr_override(wr_override), .wr_data(wr_data)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic hold(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic bus_start();
    m_sda = 1'b1; scl = 1'b1; hold(Q);
    m_sda = 1'b0; hold(2*Q);
    scl = 1'b0; hold(Q);
  endtask

  task automatic bus_restart();
    m_sda = 1'b1; hold(Q);
    scl = 1'b1; hold(2*Q);
    m_sda = 1'b0; hold(2*Q);
    scl = 1'b0; hold(Q);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; hold(Q);
    scl = 1'b1; hold(2*Q);
    m_sda = 1'b1; hold(2*Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; hold(Q);
      scl = 1'b1; hold(2*Q);
      scl = 1'b0; hold(Q);
    end
    m_sda = 1'b1; hold(Q);
    scl = 1'b1; hold(Q);
    acked = !sda_line;
    hold(Q);
    scl = 1'b0; hold(Q);
  endtask

  task automatic recv_byte(output logic [7:0] b, input bit give_ack);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      hold(Q);
      scl = 1'b1; hold(Q);
      b[i] = sda_line;
      hold(Q);
      scl = 1'b0; hold(Q);
    end
    m_sda = give_ack ? 1'b0 : 1'b1; hold(Q);
    scl = 1'b1; hold(2*Q);
    scl = 1'b0; hold(Q);
    m_sda = 1'b1;
  endtask

  // write a byte and expect an acknowledge
  task automatic wr_ack(input logic [7:0] b, input string tag);
    bit a;
    send_byte(b, a);
    check(a, tag, a, 1);
  endtask

  task automatic drained(input string tag);
    hold(20);
    check(exp_q.size() == 0, tag, exp_q.size(), 0);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && wr_valid && wr_ready) begin
      if (exp_q.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL R5 unexpected item actual=%0h expected=none",
                 {wr_chan, wr_shutdown, wr_fuse, wr_override, wr_data});
      end else begin
        logic [11:0] e;
        e = exp_q.pop_front();
        check({wr_chan, wr_shutdown, wr_fuse, wr_override, wr_data} == e,
              "R5 item", {wr_chan, wr_shutdown, wr_fuse, wr_override, wr_data}, e);
      end
    end
  end

  // R9 observer: enable must not move while SCL is high
  always @(negedge clk) begin
    if (rst_n && scl && (sda_oe != oe_last)) bad_oe++;
    oe_last = sda_oe;
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    logic [7:0] rb;
    bit a;
    hold(5);
    check(sda_oe == 1'b0 && wr_valid == 1'b0, "R1 reset", {sda_oe, wr_valid}, 0);
    rst_n = 1'b1;
    hold(10);
    check(sda_oe == 1'b0 && wr_valid == 1'b0, "R1 after reset", {sda_oe, wr_valid}, 0);

    // R2 R4 R5: channel A, two data bytes
    exp_q.push_back({4'b0000, 8'h3C});
    exp_q.push_back({4'b0000, 8'hA5});
    bus_start();
    wr_ack(8'h5C, "R2 write address ack");
    wr_ack(8'h00, "R4 instruction ack");
    wr_ack(8'h3C, "R5 data ack 1");
    wr_ack(8'hA5, "R5 data ack 2");
    bus_stop();
    drained("R5 two items");

    // R4: channel B with all control bits
    exp_q.push_back({4'b1111, 8'h7F});
    bus_start();
    wr_ack(8'h5C, "R2 write address ack");
    wr_ack(8'hE8, "R4 control bits ack");
    wr_ack(8'h7F, "R4 data ack");
    bus_stop();
    drained("R4 control item");

    // R7 R8: read channel B, status, wiper again
    bus_start();
    wr_ack(8'h5D, "R2 read address ack");
    recv_byte(rb, 1'b1);
    check(rb == 8'h9A, "R7 wiper of channel B", rb, 8'h9A);
    recv_byte(rb, 1'b1);
    check(rb == 8'h80, "R8 status byte", rb, 8'h80);
    recv_byte(rb, 1'b0);
    check(rb == 8'h9A, "R8 alternation", rb, 8'h9A);
    hold(Q);
    check(sda_oe == 1'b0, "R8 released after nack", sda_oe, 0);
    bus_stop();

    // R6: reserved bit set, channel A requested
    bus_start();
    wr_ack(8'h5C, "R2 write address ack");
    wr_ack(8'h10, "R6 reserved instruction ack");
    wr_ack(8'h55, "R6 data ack");
    bus_stop();
    drained("R6 no item");
    bus_start();
    wr_ack(8'h5D, "R2 read address ack");
    recv_byte(rb, 1'b0);
    check(rb == 8'h9A, "R6 selection kept", rb, 8'h9A);
    bus_stop();

    // R3: wrong strap bits, then a foreign address
    bus_start();
    send_byte(8'h5E, a);
    check(!a, "R3 mismatch no ack", a, 0);
    send_byte(8'h00, a);
    check(!a, "R3 ignored instruction", a, 0);
    send_byte(8'h44, a);
    check(!a, "R3 ignored data", a, 0);
    bus_stop();
    bus_start();
    send_byte(8'h90, a);
    check(!a, "R3 foreign address", a, 0);
    bus_stop();
    drained("R3 no item");

    // R11: select channel A then repeated START into a read
    bus_start();
    wr_ack(8'h5C, "R11 write address ack");
    wr_ack(8'h00, "R11 instruction ack");
    bus_restart();
    wr_ack(8'h5D, "R11 read address after restart");
    recv_byte(rb, 1'b0);
    check(rb == 8'h21, "R11 read after restart", rb, 8'h21);
    bus_stop();
    drained("R11 no item");

    // R10: stalled consumer, newest item wins
    @(posedge clk); #1 wr_ready = 1'b0;
    bus_start();
    wr_ack(8'h5C, "R10 address ack");
    wr_ack(8'h80, "R10 instruction ack");
    wr_ack(8'h11, "R10 data ack 1");
    wr_ack(8'h22, "R10 data ack 2");
    bus_stop();
    hold(5);
    check(wr_valid == 1'b1, "R10 held valid", wr_valid, 1);
    check(wr_data == 8'h22 && wr_chan == 1'b1, "R10 newest item",
          {wr_chan, wr_data}, {1'b1, 8'h22});
    exp_q.push_back({4'b1000, 8'h22});
    @(posedge clk); #1 wr_ready = 1'b1;
    drained("R10 single item");
    check(wr_valid == 1'b0, "R10 cleared", wr_valid, 0);

    check(bad_oe == 0, "R9 oe moved with SCL high", bad_oe, 0);
    finish_run();
  end
endmodule